// File: doc/BRIEF.md
# Minimum-Error Binary Band Search

This block picks the switched-capacitor bank code that brings an oscillator closest to a requested frequency. While the tuning voltage is parked at a fixed mid-range level (held by circuitry outside this block), it walks a 7-bit bank code in successive-approximation order from the most significant bit down. At every step it asks an external frequency counter for a measurement, then compares the returned count with a target that carries 7 fractional bits. The sign of the difference steers the next bit. The fractional target resolves the comparison below one count, so no fractional-divider modulation is needed during the search.

Alongside the binary walk, the block remembers the absolute error and the code of the best candidate seen so far. When the seventh measurement has been taken, it does not report the code where the walk stopped. It reports the code with the smallest absolute error among all seven visited codes. That candidate may come from an early step. Both the frequency counter and the oscillator lie outside the block.

Top module: `capbank_min_err_search`

## Requirements
- R1: During and after synchronous reset, `meas_req_o`, `done_o`, `code_o` and `final_code_o` are all zero.
- R2: A `start_i` seen high while no search is running begins a search. In the next cycle `code_o` is 0x40 (only bit 6 set), `meas_req_o` is high and `done_o` is low.
- R3: `meas_req_o` is a one-cycle pulse. A result is accepted on the first cycle after the pulse with `meas_vld_i` high. For every step except the last, the next request pulse comes in the cycle right after acceptance.
- R4: The step error is `{meas_cnt_i, 7'b0}` minus `target_i`, where `target_i[18:7]` is the integer part and `target_i[6:0]` the fraction. If the error is non-negative (oscillator not slower than target), the bit under test stays set. If it is negative, that bit is cleared. Then the next lower bit is set, and the new code appears on `code_o` with the next request.
- R5: A search takes exactly 7 measurements. After the seventh, no further request is issued until a new start.
- R6: `final_code_o` is the visited code with the smallest absolute error. If two visited codes have equal absolute error, the one visited first wins.
- R7: `done_o` rises in the cycle after the seventh measurement is accepted and stays high until the next start. While it is high, `code_o` equals `final_code_o` and both hold steady.
- R8: A `start_i` pulse while a search is in progress is ignored: the walk, its codes and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search when idle |
| target_i | input | 19 | Target count, 12 integer bits above 7 fractional bits |
| meas_req_o | output | 1 | One-cycle request for a frequency count at the current code |
| meas_vld_i | input | 1 | Count result valid |
| meas_cnt_i | input | 12 | Measured oscillator count |
| code_o | output | 7 | Bank code applied to the oscillator |
| done_o | output | 1 | Search complete, result valid |
| final_code_o | output | 7 | Code with the smallest absolute error |

## Verification
The situations hardest to reach from the ports are the case where the best code lies several steps before the last one, and exact ties between two visited codes. A plain monotonic sweep rarely lands on either. To reach them, the bench drives targets at the exact count of every code, at the midpoint between every pair of adjacent codes (which forces equal magnitudes), and at fractional offsets. It uses a nonlinear count-versus-code model so that the step sizes differ along the curve. Start pulses injected while the block waits for a result, together with varied result latency, cover the ignored-start and handshake rules.

// File: rtl/bsrch_pkg.sv
`timescale 1ns/1ps
package bsrch_pkg;
    localparam int unsigned CODE_W_DEF = 7;
    localparam int unsigned FRAC_W_DEF = 7;
    localparam int unsigned CNT_W_DEF  = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } srch_state_e;

    // Outcome of one comparison step
    typedef struct packed {
        logic too_slow;   // measured count below target
        logic accept;     // result taken this cycle
    } step_evt_t;
endpackage

// File: rtl/bs_err_calc.sv
`timescale 1ns/1ps
module bs_err_calc #(
    parameter int unsigned CNT_W  = bsrch_pkg::CNT_W_DEF,
    parameter int unsigned FRAC_W = bsrch_pkg::FRAC_W_DEF,
    localparam int unsigned TGT_W = CNT_W + FRAC_W,
    localparam int unsigned ERR_W = TGT_W + 1
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [TGT_W-1:0] target_i,
    output logic             neg_o,
    output logic [ERR_W-1:0] mag_o
);
    logic signed [ERR_W-1:0] scaled_s;
    logic signed [ERR_W-1:0] tgt_s;
    logic signed [ERR_W-1:0] diff_s;

    always_comb begin
        scaled_s = signed'({1'b0, cnt_i, {FRAC_W{1'b0}}});
        tgt_s    = signed'({1'b0, target_i});
        diff_s   = scaled_s - tgt_s;
        neg_o    = diff_s[ERR_W-1];
        mag_o    = neg_o ? unsigned'(-diff_s) : unsigned'(diff_s);
    end
endmodule

// File: rtl/bs_best_track.sv
`timescale 1ns/1ps
module bs_best_track #(
    parameter int unsigned CODE_W = bsrch_pkg::CODE_W_DEF,
    parameter int unsigned ERR_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              first_i,
    input  logic [ERR_W-1:0]  mag_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] best_code_o
);
    logic [ERR_W-1:0]  best_mag_q;
    logic [CODE_W-1:0] best_code_q;
    logic              take;

    // strict less-than keeps the earlier code on a tie
    assign take = accept_i && (first_i || (mag_i < best_mag_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            best_mag_q  <= '0;
            best_code_q <= '0;
        end else if (take) begin
            best_mag_q  <= mag_i;
            best_code_q <= code_i;
        end
    end

    assign best_code_o = best_code_q;
endmodule

// File: rtl/bs_sar_ctrl.sv
`timescale 1ns/1ps
module bs_sar_ctrl #(
    parameter int unsigned CODE_W = bsrch_pkg::CODE_W_DEF,
    localparam int unsigned BIT_W = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              meas_vld_i,
    input  logic              too_slow_i,
    output logic [CODE_W-1:0] code_o,
    output logic              meas_req_o,
    output logic              accept_o,
    output logic              first_o,
    output logic              busy_o,
    output logic              done_o
);
    import bsrch_pkg::*;

    localparam logic [CODE_W-1:0] MSB_CODE = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(CODE_W - 1);

    srch_state_e       state_q;
    logic [CODE_W-1:0] code_q, code_n;
    logic [BIT_W-1:0]  bit_q;
    logic              first_q;
    logic              done_q;
    step_evt_t         evt;

    always_comb begin
        evt.accept   = (state_q == ST_WAIT) && meas_vld_i;
        evt.too_slow = too_slow_i;
        code_n = code_q;
        if (evt.too_slow) code_n[bit_q] = 1'b0;
        if (bit_q != '0)  code_n[bit_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            bit_q   <= '0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_ISSUE;
                        code_q  <= MSB_CODE;
                        bit_q   <= TOP_BIT;
                        first_q <= 1'b1;
                        done_q  <= 1'b0;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (evt.accept) begin
                        first_q <= 1'b0;
                        code_q  <= code_n;
                        if (bit_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_ISSUE;
                            bit_q   <= bit_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign code_o     = code_q;
    assign meas_req_o = (state_q == ST_ISSUE);
    assign accept_o   = evt.accept;
    assign first_o    = first_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
endmodule

// File: rtl/capbank_min_err_search.sv
`timescale 1ns/1ps
module capbank_min_err_search #(
    parameter int unsigned CODE_W = bsrch_pkg::CODE_W_DEF,
    parameter int unsigned CNT_W  = bsrch_pkg::CNT_W_DEF,
    parameter int unsigned FRAC_W = bsrch_pkg::FRAC_W_DEF,
    localparam int unsigned TGT_W = CNT_W + FRAC_W,
    localparam int unsigned ERR_W = TGT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  target_i,
    output logic              meas_req_o,
    input  logic              meas_vld_i,
    input  logic [CNT_W-1:0]  meas_cnt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o,
    output logic [CODE_W-1:0] final_code_o
);
    logic              too_slow;
    logic [ERR_W-1:0]  mag;
    logic [CODE_W-1:0] sar_code;
    logic [CODE_W-1:0] best_code;
    logic              accept;
    logic              first;
    logic              busy;
    logic              done;

    bs_err_calc #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_err (
        .cnt_i    (meas_cnt_i),
        .target_i (target_i),
        .neg_o    (too_slow),
        .mag_o    (mag)
    );

    bs_sar_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .meas_vld_i (meas_vld_i),
        .too_slow_i (too_slow),
        .code_o     (sar_code),
        .meas_req_o (meas_req_o),
        .accept_o   (accept),
        .first_o    (first),
        .busy_o     (busy),
        .done_o     (done)
    );

    bs_best_track #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_best (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .first_i     (first),
        .mag_i       (mag),
        .code_i      (sar_code),
        .best_code_o (best_code)
    );

    assign code_o       = done ? best_code : sar_code;
    assign done_o       = done;
    assign final_code_o = best_code;
endmodule

// File: rtl/bs_checker.sv
`timescale 1ns/1ps
module bs_checker #(
    parameter int unsigned CODE_W = bsrch_pkg::CODE_W_DEF,
    localparam int unsigned ACC_W = $clog2(CODE_W + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              meas_req_o,
    input logic              meas_vld_i,
    input logic              busy,
    input logic              done_o,
    input logic [CODE_W-1:0] code_o,
    input logic [CODE_W-1:0] final_code_o
);
    localparam logic [CODE_W-1:0] MSB_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [ACC_W-1:0] acc_q;
    always_ff @(posedge clk) begin
        if (rst)                               acc_q <= '0;
        else if (start_i && !busy)             acc_q <= '0;
        else if (busy && !meas_req_o && meas_vld_i) acc_q <= acc_q + 1'b1;
    end

    AST_START_LOADS_MSB: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy) |=> (meas_req_o && code_o == MSB_CODE && !done_o)); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        meas_req_o |=> !meas_req_o); // R3
    AST_WAIT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (busy && !meas_req_o && !meas_vld_i) |=> !meas_req_o); // R8
    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (acc_q == ACC_W'(CODE_W))); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !meas_req_o); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(final_code_o) && $stable(code_o))); // R7
    AST_CODE_IS_FINAL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (code_o == final_code_o)); // R7
endmodule

bind capbank_min_err_search bs_checker #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .meas_req_o   (meas_req_o),
    .meas_vld_i   (meas_vld_i),
    .busy         (busy),
    .done_o       (done_o),
    .code_o       (code_o),
    .final_code_o (final_code_o)
);

// File: tb/sim_capbank_min_err_search.sv
`timescale 1ns/1ps
module sim_capbank_min_err_search;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [18:0] target_i = '0;
    logic        meas_req_o;
    logic        meas_vld_i = 1'b0;
    logic [11:0] meas_cnt_i = '0;
    logic [6:0]  code_o;
    logic        done_o;
    logic [6:0]  final_code_o;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    always #10 clk = ~clk;

    capbank_min_err_search u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
        .meas_req_o(meas_req_o), .meas_vld_i(meas_vld_i), .meas_cnt_i(meas_cnt_i),
        .code_o(code_o), .done_o(done_o), .final_code_o(final_code_o)
    );

    // nonlinear oscillator model: count falls as capacitance code rises
    function automatic longint cnt_of(input longint c);
        return 3000 - 12 * c - (c * c) / 16;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_search(input longint tgt, input bit poke);
        longint exp_code[7];
        longint c, best, bc, err, mag;
        c = 64; best = 0; bc = 0;
        for (int s = 0; s < 7; s++) begin
            int b = 6 - s;
            exp_code[s] = c;
            err = cnt_of(c) * 128 - tgt;
            mag = (err < 0) ? -err : err;
            if (s == 0 || mag < best) begin best = mag; bc = c; end
            if (err < 0) c = c & ~(longint'(1) << b);
            if (b > 0)   c = c | (longint'(1) << (b - 1));
        end

        @(negedge clk);
        target_i = tgt[18:0];
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        chk(meas_req_o == 1'b1, "R2 req", meas_req_o, 1);
        chk(code_o == 7'h40, "R2 code", code_o, 64);
        chk(done_o == 1'b0, "R7 done low", done_o, 0);
        for (int s = 0; s < 7; s++) begin
            int lat = int'((tgt + s) % 3);
            chk(code_o == exp_code[s][6:0], "R4 step code", code_o, exp_code[s]);
            @(negedge clk);
            chk(meas_req_o == 1'b0, "R3 pulse", meas_req_o, 0);
            if (poke && s == 3) begin
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(meas_req_o == 1'b0, "R8 no restart", meas_req_o, 0);
                chk(code_o == exp_code[s][6:0], "R8 code held", code_o, exp_code[s]);
            end
            repeat (lat) @(negedge clk);
            meas_vld_i = 1'b1;
            meas_cnt_i = 12'(cnt_of(longint'(code_o)));
            @(negedge clk);
            meas_vld_i = 1'b0;
            if (s < 6) chk(meas_req_o == 1'b1, "R3 next req", meas_req_o, 1);
            else begin
                chk(done_o == 1'b1, "R7 done rise", done_o, 1);
                chk(meas_req_o == 1'b0, "R5 no 8th req", meas_req_o, 0);
            end
        end
        chk(final_code_o == bc[6:0], "R6 best code", final_code_o, bc);
        chk(code_o == bc[6:0], "R7 code out", code_o, bc);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(meas_req_o == 1'b0, "R5 quiet", meas_req_o, 0);
            chk(done_o == 1'b1 && final_code_o == bc[6:0], "R7 hold", final_code_o, bc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(meas_req_o == 1'b0 && done_o == 1'b0, "R1 ctrl", {meas_req_o, done_o}, 0);
        chk(code_o == 7'd0 && final_code_o == 7'd0, "R1 codes", code_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(meas_req_o == 1'b0 && done_o == 1'b0, "R1 after", {meas_req_o, done_o}, 0);

        // exact hits on every code
        for (int c = 0; c < 128; c++) run_search(cnt_of(c) * 128, (c % 5) == 0);
        // midpoints between neighbours: forces equal magnitudes
        for (int c = 0; c < 127; c++) run_search((cnt_of(c) + cnt_of(c + 1)) * 64, 1'b0);
        // fractional targets across the range
        for (int i = 0; i < 64; i++) run_search(longint'(450 * 128 + i * 4300 + (i * 37) % 128), (i % 4) == 1);
        // extremes
        run_search(0, 1'b0);
        run_search(longint'(19'h7FFFF), 1'b1);

        over = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule